// File: doc/BRIEF.md
# MII Management Frame Controller

This block runs the two-wire management bus that a MAC uses to reach the registers of an Ethernet PHY. Host software programs a clock divider and an enable bit through a small register port. It then writes one 32-bit word that already holds the whole clause-22 frame: start pattern, opcode, PHY address, register address, turnaround and data. That write makes the controller send 32 preamble ones followed by the 32 command bits on MDIO, timed by the MDC clock it generates.

For a read, the controller releases MDIO from the turnaround bits onward. It shifts in the 16 bits the PHY returns and places them in the low half of the data register. Completion of any frame sets a sticky event bit, which software clears by writing a one to it. No busy bit exists: software waits for the event bit. A data-register write made while a frame is in flight is dropped.

Top module: `mdio_ctrl`

## Requirements
- R1: A launched frame presents 32 ones and then command bits 31 down to 0, one bit per MDC period. The command fields are start [31:30]=01, opcode [29:28], PHY address [27:23], register address [22:18], turnaround [17:16]=10 and data [15:0].
- R2: With a nonzero divider field N, held in bits [6:1] of the speed register (address 1), MDC has a period of 2N system clocks with equal high and low times.
- R3: With N equal to 0, MDC stays low and a data-register write starts no frame. The written word is still stored.
- R4: A frame starts only if bit 0 of the control register (address 0) is 1 when the data register (address 2) is written.
- R5: For any opcode other than 10 (a write, top nibble 0x5), the output enable is high for all 64 frame bits, and only while a frame runs.
- R6: For a read (opcode 10, top nibble 0x6), the output enable is high for the first 46 bits and low from the turnaround bits onward. The 16 bits sampled in the data phase, MSB first, replace data-register bits [15:0]; bits [31:16] keep the command.
- R7: Frame completion sets bit 23 of the event register (address 3). Writing a word with bit 23 set clears it. Writing a word with bit 23 clear leaves it unchanged.
- R8: A data-register write while a frame runs is ignored: the frame, the stored word and the number of frames are unchanged.
- R9: MDIO data and output enable change only at MDC falling edges; the bench samples on rising edges.
- R10: After reset, all four registers read zero, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 speed, 2 data, 3 event |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the block with its default parameters: a 6-bit divider field, a 32-bit command word, a 32-bit preamble and 16 read bits. At run time it programs divider values 0 to 3. The short MDC periods this gives let many complete 64-bit frames, random reads and writes and the busy-write case fit in a short run. They also make the 2N period measurable at its smallest values and reach the held-low case of a zero divider.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_SPEED = 2'd1;
    localparam logic [1:0] ADDR_DATA  = 2'd2;
    localparam logic [1:0] ADDR_EVENT = 2'd3;
    localparam logic [1:0] OP_READ    = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d = st_q;
        tick = (div != '0) && (st_q.cnt >= div - 1'b1);
        if (div == '0) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (tick) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        rise_stb = tick && !st_q.mdc;
        fall_stb = tick && st_q.mdc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.mdc;
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
    parameter int CMD_W   = 32,
    parameter int PRE_LEN = 32,
    parameter int RD_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [CMD_W-1:0] cmd,
    input  logic             rise_stb,
    input  logic             fall_stb,
    input  logic             mdio_i,
    output logic             busy,
    output logic             done,
    output logic [RD_W-1:0]  rdata,
    output logic             mdio_o,
    output logic             mdio_oe
);
    import mdio_pkg::*;

    localparam int TOT      = PRE_LEN + CMD_W;
    localparam int PW       = $clog2(TOT + 1);
    localparam int CW       = $clog2(CMD_W);
    localparam int TA_POS   = TOT - RD_W - 2;
    localparam int DATA_POS = TOT - RD_W;

    typedef struct packed {
        logic             busy;
        logic [PW-1:0]    pos;
        logic [CMD_W-1:0] cmd;
        logic             is_rd;
        logic             out;
        logic             oe;
        logic [RD_W-1:0]  rd;
    } sh_st_t;

    sh_st_t        st_d, st_q;
    logic [PW-1:0] rel;

    always_comb begin
        st_d = st_q;
        rel  = PW'(TOT - 1) - st_q.pos;
        done = st_q.busy && fall_stb && (st_q.pos == PW'(TOT));
        if (!st_q.busy) begin
            if (launch) begin
                st_d.busy  = 1'b1;
                st_d.pos   = '0;
                st_d.cmd   = cmd;
                st_d.is_rd = (cmd[CMD_W-3:CMD_W-4] == OP_READ);
                st_d.rd    = '0;
            end
        end else begin
            if (fall_stb) begin
                if (done) begin
                    st_d.busy = 1'b0;
                    st_d.oe   = 1'b0;
                    st_d.out  = 1'b0;
                end else begin
                    st_d.out = (st_q.pos < PW'(PRE_LEN)) ? 1'b1 : st_q.cmd[rel[CW-1:0]];
                    st_d.oe  = !(st_q.is_rd && (st_q.pos >= PW'(TA_POS)));
                    st_d.pos = st_q.pos + 1'b1;
                end
            end
            if (rise_stb && st_q.is_rd && (st_q.pos > PW'(DATA_POS))) begin
                st_d.rd = {st_q.rd[RD_W-2:0], mdio_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign rdata   = st_q.rd;
    assign mdio_o  = st_q.out;
    assign mdio_oe = st_q.oe;
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl #(
    parameter int DIV_W   = 6,
    parameter int CMD_W   = 32,
    parameter int PRE_LEN = 32,
    parameter int RD_W    = 16,
    parameter int EVT_BIT = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CMD_W-1:0] reg_wdata,
    output logic [CMD_W-1:0] reg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    import mdio_pkg::*;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic [CMD_W-1:0] data;
        logic             evt;
    } regs_t;

    regs_t            st_d, st_q;
    logic             rise_stb, fall_stb;
    logic             frame_busy, frame_done, launch;
    logic [RD_W-1:0]  frame_rd;
    logic             en_q, evt_q;
    logic [DIV_W-1:0] div_q;
    logic [CMD_W-1:0] data_q;

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .div(st_q.div),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_shifter #(.CMD_W(CMD_W), .PRE_LEN(PRE_LEN), .RD_W(RD_W)) u_sh (
        .clk(clk), .rst_n(rst_n), .launch(launch), .cmd(reg_wdata),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
        .busy(frame_busy), .done(frame_done), .rdata(frame_rd),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always_comb begin
        st_d   = st_q;
        launch = reg_wr && (reg_addr == ADDR_DATA) && !frame_busy
                 && st_q.en && (st_q.div != '0);
        if (reg_wr && (reg_addr == ADDR_CTRL))  st_d.en  = reg_wdata[0];
        if (reg_wr && (reg_addr == ADDR_SPEED)) st_d.div = reg_wdata[DIV_W:1];
        if (reg_wr && (reg_addr == ADDR_DATA) && !frame_busy) st_d.data = reg_wdata;
        if (frame_done && (st_q.data[CMD_W-3:CMD_W-4] == OP_READ)) st_d.data[RD_W-1:0] = frame_rd;
        if (reg_wr && (reg_addr == ADDR_EVENT) && reg_wdata[EVT_BIT]) st_d.evt = 1'b0;
        if (frame_done) st_d.evt = 1'b1;

        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL:  reg_rdata[0] = st_q.en;
            ADDR_SPEED: reg_rdata[DIV_W:1] = st_q.div;
            ADDR_DATA:  reg_rdata = st_q.data;
            default:    reg_rdata[EVT_BIT] = st_q.evt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign div_q  = st_q.div;
    assign data_q = st_q.data;
    assign evt_q  = st_q.evt;
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk #(
    parameter int DIV_W = 6,
    parameter int CMD_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             evt_clr_bit,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             busy,
    input logic             done,
    input logic             en,
    input logic [DIV_W-1:0] div,
    input logic [CMD_W-1:0] data,
    input logic             evt
);
    a_r9_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    a_r3_div0_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |=> !mdc);

    a_r7_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !(reg_wr && reg_addr == 2'd3 && evt_clr_bit)) |=> evt);

    a_r8_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && reg_wr && reg_addr == 2'd2) |=> $stable(data));

    a_r4_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en));

    a_r5_oe_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);
endmodule

bind mdio_ctrl mdio_ctrl_chk #(.DIV_W(DIV_W), .CMD_W(CMD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .evt_clr_bit(reg_wdata[EVT_BIT]), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .busy(frame_busy), .done(frame_done), .en(en_q),
    .div(div_q), .data(data_q), .evt(evt_q)
);

// File: tb/mdio_ctrl_test.sv
module mdio_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int EVT = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] cap, oe_hist;
    logic [15:0] resp;
    int          rc;
    logic        armed, active, oe_seen;

    mdio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // PHY model: captures on MDC rise, drives read data after MDC fall
    always @(posedge mdc) begin
        if (active && rc < 64) begin
            cap     = {cap[62:0], mdio_o};
            oe_hist = {oe_hist[62:0], mdio_oe};
            rc      = rc + 1;
            if (rc == 64) active = 1'b0;
        end
    end
    always @(negedge mdc) begin
        if (armed) begin
            armed  = 1'b0;
            active = 1'b1;
        end else if (rc >= 48 && rc < 64) begin
            mdio_i = resp[63 - rc];
        end else begin
            mdio_i = 1'b1;
        end
    end
    always @(posedge clk) if (mdio_oe) oe_seen = 1'b1;

    function automatic logic [63:0] exp_frame(input logic [31:0] c);
        return {32'hFFFF_FFFF, c};
    endfunction
    function automatic logic [63:0] exp_oe(input logic [31:0] c);
        return (c[29:28] == 2'b10) ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    endfunction
    function automatic logic [31:0] exp_data(input logic [31:0] c, input logic [15:0] r);
        return (c[29:28] == 2'b10) ? {c[31:16], r} : c;
    endfunction
    function automatic logic [31:0] mk_cmd(input logic rd, input logic [4:0] phy,
                                           input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, rd ? 2'b10 : 2'b01, phy, ra, 2'b10, rd ? 16'h0 : d};
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic launch(input logic [31:0] c);
        rc = 0; active = 1'b0; armed = 1'b0;
        wr(2'd2, c);
        armed = 1'b1;
    endtask

    task automatic wait_evt(output logic got);
        logic [31:0] v;
        got = 1'b0;
        for (int i = 0; i < 3000 && !got; i++) begin
            rd(2'd3, v);
            got = v[EVT];
        end
    endtask

    task automatic run_frame(input logic [31:0] c, input string tag);
        logic        got;
        logic [31:0] v;
        launch(c);
        wait_evt(got);
        check(got, {tag, " R7 event set"}, 64'(got), 64'd1);
        check(rc == 64, {tag, " R1 bit count"}, 64'(rc), 64'd64);
        check((cap & exp_oe(c)) == (exp_frame(c) & exp_oe(c)), {tag, " R1 frame bits"},
              cap & exp_oe(c), exp_frame(c) & exp_oe(c));
        check(oe_hist == exp_oe(c), {tag, (c[29:28] == 2'b10) ? " R6 oe" : " R5 oe"},
              oe_hist, exp_oe(c));
        rd(2'd2, v);
        check(v == exp_data(c, resp), {tag, " R6 data register"}, 64'(v), 64'(exp_data(c, resp)));
        wr(2'd3, 32'h1 << EVT);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, c1;
        logic        got;
        time         t1, t2;
        cap = '0; oe_hist = '0; rc = 0; armed = 0; active = 0; oe_seen = 0;
        resp = 16'hA5C3;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R10 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 0, "R10 register reset", 64'(v), 64'd0);
        end
        check(!mdc && !mdio_oe, "R10 mdc/oe low", {62'd0, mdc, mdio_oe}, 64'd0);

        // R3 zero divider: mdc held low, no frame
        wr(2'd0, 32'h1);
        oe_seen = 0;
        launch(32'h5012_1234);
        got = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mdc) got = 1;
        end
        check(!got, "R3 mdc low with zero divider", 64'(got), 64'd0);
        rd(2'd3, v);
        check(v[EVT] == 0 && !oe_seen, "R3 no frame", 64'(v), 64'd0);
        rd(2'd2, v);
        check(v == 32'h5012_1234, "R3 word stored", 64'(v), 64'h5012_1234);

        // R2 period 2N
        for (int n = 1; n <= 3; n += 2) begin
            wr(2'd1, 32'(n << 1));
            @(posedge mdc); t1 = $time;
            @(posedge mdc); t2 = $time;
            check((t2 - t1) == time'(2 * n * CLK_PERIOD), "R2 MDC period",
                  64'(t2 - t1), 64'(2 * n * CLK_PERIOD));
        end

        // R4 disabled: no frame
        wr(2'd0, 32'h0);
        wr(2'd1, 32'(2 << 1));
        oe_seen = 0;
        launch(32'h5012_4321);
        repeat (600) @(negedge clk);
        rd(2'd3, v);
        check(v[EVT] == 0 && !oe_seen, "R4 no frame when disabled", {v[EVT], oe_seen}, 64'd0);
        wr(2'd0, 32'h1);

        // directed write and read
        run_frame(mk_cmd(0, 5'd1, 5'd0, 16'hBEEF), "dir-write");
        resp = 16'h8001;
        run_frame(mk_cmd(1, 5'd31, 5'd31, 16'h0), "dir-read");

        // R7 write-1-to-clear behaviour
        launch(mk_cmd(0, 5'd3, 5'd4, 16'h0F0F));
        wait_evt(got);
        wr(2'd3, 32'hFF7F_FFFF);
        rd(2'd3, v);
        check(v[EVT] == 1, "R7 write of 0 keeps event", 64'(v), 64'h800000);
        wr(2'd3, 32'h0080_0000);
        rd(2'd3, v);
        check(v == 0, "R7 write of 1 clears event", 64'(v), 64'd0);

        // R8 write during frame ignored
        c1 = mk_cmd(0, 5'd9, 5'd2, 16'h1357);
        launch(c1);
        repeat (60) @(negedge clk);
        wr(2'd2, 32'h6FFF_0000);
        wait_evt(got);
        check(cap == exp_frame(c1), "R8 frame unchanged", cap, exp_frame(c1));
        rd(2'd2, v);
        check(v == c1, "R8 stored word unchanged", 64'(v), 64'(c1));
        wr(2'd3, 32'h1 << EVT);
        oe_seen = 0;
        repeat (600) @(negedge clk);
        rd(2'd3, v);
        check(v[EVT] == 0 && !oe_seen, "R8 no extra frame", {v[EVT], oe_seen}, 64'd0);

        // random frames
        for (int k = 0; k < 10; k++) begin
            wr(2'd1, 32'((1 + ($urandom % 3)) << 1));
            resp = 16'($urandom);
            run_frame(mk_cmd(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom)), "rand");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule